// File: doc/BRIEF.md
# Data Bus Inversion Codec

This block sits between a core-side 64-bit data path and an active-low bus. The bus is split into four 16-bit lanes, and each lane has its own active-low inversion flag. On the transmit side it takes a 64-byte line as eight 64-bit beats. For each beat and each lane it decides whether to send that lane inverted, so that no lane pulls more than half of its wires low. It then drives the coded wire levels together with the four flag levels. On the receive side it takes coded wire levels and flag levels and restores the original data.

Each direction counts its accepted beats and marks the eighth one with a line-done strobe, then starts over. A beat is accepted when its valid input is high. When valid is low the input is ignored. Both directions have a fixed latency of one clock.

Top module: `dbi_codec`

## Requirements
- R1: Flag bit k (tx_inv_n[k], rx_inv_n[k]) governs data bits 16k+15 down to 16k, for k = 0..3. Lane 0 is bits 15:0 and lane 3 is bits 63:48.
- R2: On transmit, a lane is inverted when more than 8 of its 16 data bits are 1, and is sent as-is otherwise. Exactly 8 ones leaves the lane uninverted.
- R3: On every valid transmitted beat, each 16-bit lane of tx_bus_n has at most 8 wires at level 0.
- R4: The wires are active-low. tx_bus_n equals the bitwise NOT of the coded data, where the coded data is the data XOR the lane inversion mask. A flag level of 0 means the lane is inverted.
- R5: On receive, rx_data equals NOT rx_bus_n, XOR a mask in which each lane is all ones where rx_inv_n[k] is 0. Feeding the encoder output into the decoder returns the original data bit for bit.
- R6: The inversion decision is made afresh on every beat. It does not depend on earlier beats.
- R7: Each output appears exactly one clock after the accepted input. tx_beat_vld and rx_beat_vld are the valid inputs delayed by one clock.
- R8: In each direction, the line-done strobe is high together with the beat-valid strobe of the 8th, 16th, ... accepted beat since reset, and low otherwise.
- R9: A beat with valid low is ignored. The beat count does not advance. During the following clock, tx_bus_n and tx_inv_n are all ones. rx_data holds its previous value.
- R10: A synchronous active-high reset clears both beat counts and sets tx_bus_n and tx_inv_n to all ones. It sets rx_data to zero and all strobes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_valid | input | 1 | Transmit beat present |
| tx_data | input | 64 | Transmit beat, true data |
| tx_bus_n | output | 64 | Coded wire levels, active low |
| tx_inv_n | output | 4 | Lane inversion flag levels, active low |
| tx_beat_vld | output | 1 | Coded transmit beat present on outputs |
| tx_line_done | output | 1 | Last beat of a transmit line |
| rx_valid | input | 1 | Receive beat present |
| rx_bus_n | input | 64 | Received wire levels, active low |
| rx_inv_n | input | 4 | Received flag levels, active low |
| rx_data | output | 64 | Restored receive data |
| rx_beat_vld | output | 1 | Restored receive beat present |
| rx_line_done | output | 1 | Last beat of a receive line |

## Verification
Every result of either direction is due one clock after the beat that caused it: coded wires, flags, restored data, beat-valid and line-done. The bench applies inputs on a falling edge and compares all outputs at the next falling edge. At that point exactly one register stage has updated. In the loopback case, the encoder output sampled in one step is fed to the decoder in the next step. The restored data is checked one step after that.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
    localparam int unsigned DBI_DATA_W_DEF = 64;
    localparam int unsigned DBI_LANE_W_DEF = 16;
    localparam int unsigned DBI_BEATS_DEF  = 8;
endpackage

// File: rtl/dbi_lane_enc.sv
module dbi_lane_enc #(
    parameter int unsigned LANE_W = 16
) (
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic              inv
);
    localparam int unsigned CNT_W = $clog2(LANE_W + 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(LANE_W / 2);

    logic [CNT_W-1:0] ones;

    // Ones in the true data become low wires, so count them.
    always_comb begin
        ones = '0;
        for (int i = 0; i < LANE_W; i++) begin
            ones = ones + CNT_W'(din[i]);
        end
    end

    assign inv  = (ones > HALF);
    assign dout = inv ? ~din : din;
endmodule

// File: rtl/dbi_lane_dec.sv
module dbi_lane_dec #(
    parameter int unsigned LANE_W = 16
) (
    input  logic [LANE_W-1:0] din,
    input  logic              inv,
    output logic [LANE_W-1:0] dout
);
    assign dout = din ^ {LANE_W{inv}};
endmodule

// File: rtl/dbi_beat_ctr.sv
module dbi_beat_ctr #(
    parameter int unsigned BEATS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic last_beat
);
    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (adv) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign last_beat = adv && (cnt_q == LAST);
endmodule

// File: rtl/dbi_codec.sv
module dbi_codec #(
    parameter int unsigned DATA_W = dbi_pkg::DBI_DATA_W_DEF,
    parameter int unsigned LANE_W = dbi_pkg::DBI_LANE_W_DEF,
    parameter int unsigned BEATS  = dbi_pkg::DBI_BEATS_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tx_valid,
    input  logic [DATA_W-1:0]           tx_data,
    output logic [DATA_W-1:0]           tx_bus_n,
    output logic [DATA_W/LANE_W-1:0]    tx_inv_n,
    output logic                        tx_beat_vld,
    output logic                        tx_line_done,
    input  logic                        rx_valid,
    input  logic [DATA_W-1:0]           rx_bus_n,
    input  logic [DATA_W/LANE_W-1:0]    rx_inv_n,
    output logic [DATA_W-1:0]           rx_data,
    output logic                        rx_beat_vld,
    output logic                        rx_line_done
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [DATA_W-1:0] tx_bus_n;
        logic [LANES-1:0]  tx_inv_n;
        logic              tx_vld;
        logic              tx_done;
        logic [DATA_W-1:0] rx_data;
        logic              rx_vld;
        logic              rx_done;
    } codec_st_t;

    localparam codec_st_t ST_RST = '{
        tx_bus_n: '1, tx_inv_n: '1, tx_vld: 1'b0, tx_done: 1'b0,
        rx_data: '0, rx_vld: 1'b0, rx_done: 1'b0
    };

    codec_st_t st_d, st_q;

    logic [DATA_W-1:0] enc_data;
    logic [LANES-1:0]  enc_inv;
    logic [DATA_W-1:0] rx_lvl;
    logic [DATA_W-1:0] dec_data;
    logic              tx_last, rx_last;

    assign rx_lvl = ~rx_bus_n;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        dbi_lane_enc #(.LANE_W(LANE_W)) u_enc (
            .din  (tx_data[k*LANE_W +: LANE_W]),
            .dout (enc_data[k*LANE_W +: LANE_W]),
            .inv  (enc_inv[k])
        );
        dbi_lane_dec #(.LANE_W(LANE_W)) u_dec (
            .din  (rx_lvl[k*LANE_W +: LANE_W]),
            .inv  (~rx_inv_n[k]),
            .dout (dec_data[k*LANE_W +: LANE_W])
        );
    end

    dbi_beat_ctr #(.BEATS(BEATS)) u_tx_ctr (
        .clk       (clk),
        .rst       (rst),
        .adv       (tx_valid),
        .last_beat (tx_last)
    );

    dbi_beat_ctr #(.BEATS(BEATS)) u_rx_ctr (
        .clk       (clk),
        .rst       (rst),
        .adv       (rx_valid),
        .last_beat (rx_last)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tx_vld  = tx_valid;
        st_d.tx_done = tx_last;
        if (tx_valid) begin
            st_d.tx_bus_n = ~enc_data;
            st_d.tx_inv_n = ~enc_inv;
        end else begin
            st_d.tx_bus_n = '1;
            st_d.tx_inv_n = '1;
        end
        st_d.rx_vld  = rx_valid;
        st_d.rx_done = rx_last;
        if (rx_valid) begin
            st_d.rx_data = dec_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RST;
        else     st_q <= st_d;
    end

    assign tx_bus_n     = st_q.tx_bus_n;
    assign tx_inv_n     = st_q.tx_inv_n;
    assign tx_beat_vld  = st_q.tx_vld;
    assign tx_line_done = st_q.tx_done;
    assign rx_data      = st_q.rx_data;
    assign rx_beat_vld  = st_q.rx_vld;
    assign rx_line_done = st_q.rx_done;
endmodule

// File: rtl/dbi_codec_chk.sv
module dbi_codec_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned LANE_W = 16,
    parameter int unsigned BEATS  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     tx_valid,
    input logic [DATA_W-1:0]        tx_bus_n,
    input logic [DATA_W/LANE_W-1:0] tx_inv_n,
    input logic                     tx_beat_vld,
    input logic                     tx_line_done,
    input logic                     rx_valid,
    input logic [DATA_W-1:0]        rx_data,
    input logic                     rx_beat_vld,
    input logic                     rx_line_done
);
    localparam int unsigned LANES = DATA_W / LANE_W;
    localparam int unsigned CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (tx_beat_vld) seen_q <= (seen_q == LAST) ? '0 : seen_q + 1'b1;
    end

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        // R3: lane low-wire bound on valid beats
        a_r3_low_limit: assert property (@(posedge clk) disable iff (rst)
            tx_beat_vld |-> ($countones(~tx_bus_n[k*LANE_W +: LANE_W]) <= (LANE_W / 2)));
        // R2: an inverted lane had a strict majority of ones, so it now drives fewer than half low
        a_r2_inv_strict: assert property (@(posedge clk) disable iff (rst)
            (tx_beat_vld && !tx_inv_n[k]) |-> ($countones(~tx_bus_n[k*LANE_W +: LANE_W]) < (LANE_W / 2)));
    end

    a_r9_tx_idle: assert property (@(posedge clk) disable iff (rst)
        !tx_beat_vld |-> (&tx_bus_n && &tx_inv_n));

    a_r7_tx_latency: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_beat_vld);

    a_r7_rx_latency: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> rx_beat_vld);

    a_r8_done_with_vld: assert property (@(posedge clk) disable iff (rst)
        (tx_line_done |-> tx_beat_vld) and (rx_line_done |-> rx_beat_vld));

    a_r8_tx_done_pos: assert property (@(posedge clk) disable iff (rst)
        tx_beat_vld |-> (tx_line_done == (seen_q == LAST)));

    a_r9_rx_hold: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> $stable(rx_data));
endmodule

bind dbi_codec dbi_codec_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W), .BEATS(BEATS)) u_chk (.*);

// File: tb/tb_dbi_codec.sv
module tb_dbi_codec;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int LW = 16;
    localparam int NL = 4;
    localparam int NB = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          tx_valid;
    logic [DW-1:0] tx_data;
    logic [DW-1:0] tx_bus_n;
    logic [NL-1:0] tx_inv_n;
    logic          tx_beat_vld, tx_line_done;
    logic          rx_valid;
    logic [DW-1:0] rx_bus_n;
    logic [NL-1:0] rx_inv_n;
    logic [DW-1:0] rx_data;
    logic          rx_beat_vld, rx_line_done;

    int n_run  = 0;
    int n_fail = 0;
    int tx_acc = 0;
    int rx_acc = 0;
    logic [DW-1:0] rx_exp = '0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbi_codec dut (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_bus_n(tx_bus_n), .tx_inv_n(tx_inv_n),
        .tx_beat_vld(tx_beat_vld), .tx_line_done(tx_line_done),
        .rx_valid(rx_valid), .rx_bus_n(rx_bus_n), .rx_inv_n(rx_inv_n),
        .rx_data(rx_data), .rx_beat_vld(rx_beat_vld), .rx_line_done(rx_line_done)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference encoder written from the requirements
    function automatic logic [DW+NL-1:0] ref_enc(input logic [DW-1:0] d);
        logic [DW-1:0] coded;
        logic [NL-1:0] inv;
        for (int k = 0; k < NL; k++) begin
            inv[k] = ($countones(d[k*LW +: LW]) > LW/2);
            coded[k*LW +: LW] = inv[k] ? ~d[k*LW +: LW] : d[k*LW +: LW];
        end
        return {~coded, ~inv};
    endfunction

    function automatic logic [DW-1:0] ref_dec(input logic [DW-1:0] b, input logic [NL-1:0] f);
        logic [DW-1:0] m;
        for (int k = 0; k < NL; k++) m[k*LW +: LW] = {LW{~f[k]}};
        return ~b ^ m;
    endfunction

    // Drive one beat in each direction, check all outputs one clock later.
    task automatic step(input logic tv, input logic [DW-1:0] td,
                        input logic rv, input logic [DW-1:0] rb, input logic [NL-1:0] ri);
        logic [DW+NL-1:0] e;
        logic exp_tdone, exp_rdone;
        tx_valid = tv; tx_data = td;
        rx_valid = rv; rx_bus_n = rb; rx_inv_n = ri;
        e = ref_enc(td);
        exp_tdone = tv && (tx_acc == NB-1);
        exp_rdone = rv && (rx_acc == NB-1);
        if (tv) tx_acc = (tx_acc + 1) % NB;
        if (rv) begin
            rx_acc = (rx_acc + 1) % NB;
            rx_exp = ref_dec(rb, ri);
        end
        @(negedge clk);
        chk(tx_beat_vld == tv, "R7 tx_beat_vld", DW'(tx_beat_vld), DW'(tv));
        chk(rx_beat_vld == rv, "R7 rx_beat_vld", DW'(rx_beat_vld), DW'(rv));
        chk(tx_line_done == exp_tdone, "R8 tx_line_done", DW'(tx_line_done), DW'(exp_tdone));
        chk(rx_line_done == exp_rdone, "R8 rx_line_done", DW'(rx_line_done), DW'(exp_rdone));
        chk(rx_data == rx_exp, "R5/R9 rx_data", rx_data, rx_exp);
        if (tv) begin
            chk(tx_bus_n == e[DW+NL-1:NL], "R4 tx_bus_n", tx_bus_n, e[DW+NL-1:NL]);
            chk(tx_inv_n == e[NL-1:0], "R4 tx_inv_n", DW'(tx_inv_n), DW'(e[NL-1:0]));
            for (int k = 0; k < NL; k++)
                chk($countones(~tx_bus_n[k*LW +: LW]) <= LW/2, "R3 lane low count",
                    DW'($countones(~tx_bus_n[k*LW +: LW])), DW'(LW/2));
        end else begin
            chk(&tx_bus_n && &tx_inv_n, "R9 tx idle levels", tx_bus_n, '1);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; tx_valid = 1'b1; tx_data = '1; rx_valid = 1'b1; rx_bus_n = '0; rx_inv_n = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0; tx_valid = 1'b0; rx_valid = 1'b0;
        tx_acc = 0; rx_acc = 0; rx_exp = '0;
        chk(&tx_bus_n, "R10 tx_bus_n reset", tx_bus_n, '1);
        chk(&tx_inv_n, "R10 tx_inv_n reset", DW'(tx_inv_n), DW'(4'hF));
        chk(rx_data == '0, "R10 rx_data reset", rx_data, '0);
        chk(!tx_beat_vld && !tx_line_done && !rx_beat_vld && !rx_line_done,
            "R10 strobes reset", DW'({tx_beat_vld, tx_line_done, rx_beat_vld, rx_line_done}), '0);
    endtask

    task automatic t_lane_map();
        for (int k = 0; k < NL; k++) begin
            logic [DW-1:0] d;
            d = '0;
            d[k*LW +: LW] = '1;
            step(1'b1, d, 1'b0, '1, '1);
            chk(tx_inv_n == ~(NL'(1) << k), "R1 flag lane select", DW'(tx_inv_n), DW'(~(NL'(1) << k)));
            chk(&tx_bus_n, "R1 inverted lane drives high", tx_bus_n, '1);
        end
    endtask

    task automatic t_threshold();
        // lane3 9 ones, lane2 8 ones, lane1 16 ones, lane0 none
        step(1'b1, {16'h01FF, 16'h00FF, 16'hFFFF, 16'h0000}, 1'b0, '1, '1);
        chk(tx_inv_n == 4'b0101, "R2 threshold 8 vs 9", DW'(tx_inv_n), DW'(4'b0101));
        chk($countones(~tx_bus_n[47:32]) == 8, "R2 exactly 8 sent as-is",
            DW'($countones(~tx_bus_n[47:32])), DW'(8));
    endtask

    task automatic t_per_beat();
        step(1'b1, '1, 1'b0, '1, '1);
        chk(tx_inv_n == 4'b0000, "R6 beat a all inverted", DW'(tx_inv_n), '0);
        step(1'b1, '0, 1'b0, '1, '1);
        chk(tx_inv_n == 4'b1111, "R6 beat b none inverted", DW'(tx_inv_n), DW'(4'hF));
        step(1'b1, 64'hFFFF_0000_FFFF_0000, 1'b0, '1, '1);
        chk(tx_inv_n == 4'b0101, "R6 beat c mixed", DW'(tx_inv_n), DW'(4'b0101));
    endtask

    task automatic t_rx_direct();
        step(1'b0, '0, 1'b1, 64'h0123_4567_89AB_CDEF, 4'b1010);
        step(1'b0, '0, 1'b1, 64'hFFFF_0000_5555_AAAA, 4'b0000);
        step(1'b0, '0, 1'b0, 64'h1111_1111_1111_1111, 4'b0000); // R9 rx hold
        step(1'b0, '0, 1'b1, '1, 4'b1111);
        chk(rx_data == '0, "R5 all-high uninverted decodes to zero", rx_data, '0);
    endtask

    task automatic t_loopback_gaps();
        logic [DW-1:0] lfsr, prev_d, prev_b;
        logic [NL-1:0] prev_f;
        logic prev_v;
        lfsr = 64'hACE1_2468_1357_9BDF;
        prev_v = 1'b0; prev_d = '0; prev_b = '1; prev_f = '1;
        for (int i = 0; i < 60; i++) begin
            logic v;
            v = (i % 5) != 3;
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            step(v, lfsr ^ {lfsr[31:0], lfsr[63:32]}, prev_v, prev_b, prev_f);
            if (prev_v)
                chk(rx_data == prev_d, "R5 loopback round trip", rx_data, prev_d);
            prev_v = v;
            prev_d = lfsr ^ {lfsr[31:0], lfsr[63:32]};
            prev_b = tx_bus_n; prev_f = tx_inv_n;
        end
        step(1'b0, '0, prev_v, prev_b, prev_f);
        if (prev_v) chk(rx_data == prev_d, "R5 loopback last beat", rx_data, prev_d);
    endtask

    initial begin
        tx_valid = 1'b0; tx_data = '0; rx_valid = 1'b0; rx_bus_n = '1; rx_inv_n = '1;
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_lane_map();
        t_threshold();
        t_per_beat();
        t_rx_direct();
        t_loopback_gaps();
        t_reset();
        t_loopback_gaps();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule